// File: doc/BRIEF.md
# SPI NOR Flash Erase Sequencer

This block sits on the host side of a serial NOR flash and erases one region when asked. The requester hands over a 24-bit address and a size select: 64 KB block or 4 KB sector. The sequencer then runs three kinds of SPI frames on its own. First it sends a write-enable frame. Next it sends the erase frame, which carries an opcode and the address. It then sends repeated status-read frames until the flash reports that it is no longer busy. At the end it pulses either a completion strobe or a timeout strobe.

The request side is a valid/ready handshake. `req_ready` is high only while the sequencer is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. While an erase is in progress, `req_ready` is low and nothing is queued. A requester that lowers `req_valid` before `req_ready` returns has its request dropped. The bus runs in SPI mode 0. SCK idles low. MOSI changes on the falling edge, and both the flash and the sequencer sample on the rising edge. SCK runs at the system clock divided by `2*CLK_DIV`.

Top module: `spi_erase_seq`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, `req_ready` is 1, and `busy`, `done` and `timeout_err` are 0.
- R2: The first frame of every accepted request is exactly 8 bits long and carries the value 06h, sent MSB first.
- R3: The second frame is exactly 32 bits long: an opcode followed by the 24 address bits, both MSB first, with the address passed through unchanged. The opcode is D8h when `req_block`=1 (64 KB) and 20h when `req_block`=0 (4 KB).
- R4: After the erase frame, the sequencer sends status frames of 16 clocks. Each carries 05h in its first 8 bits and samples MISO on the rising edge in its last 8 bits. The last bit sampled is status bit 0, the busy flag. Status bits 7..1 are ignored. When a status frame returns busy=0, `done` pulses for one cycle, no further frame follows, and `req_ready` returns to 1.
- R5: Between two frames of the same request, `spi_cs_n` stays high for at least `CS_GAP` system clocks.
- R6: If `MAX_POLLS` status frames in a row all return busy=1, `timeout_err` pulses for one cycle and no further frame is sent. `done` and `timeout_err` are never high together.
- R7: While a request is in progress, `req_ready` and `busy` are inverse of each other and `req_ready` is 0. A `req_valid` pulse during that time starts no extra frames and changes no frame contents.
- R8: SCK is 0 whenever `spi_cs_n` is 1. MOSI does not change on a rising SCK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Erase request valid |
| req_ready | output | 1 | High when a request can be accepted (idle) |
| req_addr | input | 24 | Byte address inside the region to erase |
| req_block | input | 1 | 1 = 64 KB block erase, 0 = 4 KB sector erase |
| busy | output | 1 | An erase sequence is in progress |
| done | output | 1 | One-cycle pulse: the flash reported not busy |
| timeout_err | output | 1 | One-cycle pulse: the poll limit ran out while busy |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The hardest cases to reach are the ends of the poll limit. One is the status read that clears on exactly the last allowed poll. The other is the read that is still busy on that poll and must give a timeout instead. A behavioural flash in the bench holds its busy flag for a chosen number of status frames. Each vector sets that number to zero, to just under the limit, to exactly the limit and to beyond it. The bench also sends a second request in the middle of a polling phase. It then confirms from the recorded frames that nothing extra went out on the bus.

// File: rtl/spi_erase_pkg.sv
package spi_erase_pkg;
  localparam int FRAME_W = 32;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  localparam logic [7:0] OP_WR_EN  = 8'h06;
  localparam logic [7:0] OP_ER_64K = 8'hD8;
  localparam logic [7:0] OP_ER_4K  = 8'h20;
  localparam logic [7:0] OP_STATUS = 8'h05;

  localparam logic [LEN_W-1:0] LEN_CMD  = LEN_W'(8);
  localparam logic [LEN_W-1:0] LEN_ERA  = LEN_W'(32);
  localparam logic [LEN_W-1:0] LEN_POLL = LEN_W'(16);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WREN,
    ST_GAP_E,
    ST_ERASE,
    ST_GAP_P,
    ST_POLL
  } seq_state_t;
endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = $clog2(HALF + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!en || cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = en && (cnt == LAST);
endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine
  import spi_erase_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [FRAME_W-1:0] tx_word,
  input  logic [LEN_W-1:0] tx_len,
  input  logic             rd_en,
  input  logic             tick,
  input  logic             miso,
  output logic             active,
  output logic             cs_n,
  output logic             sck,
  output logic             mosi,
  output logic             done,
  output logic             rx_bit
);
  logic               run_q;
  logic               tail_q;
  logic               sck_q;
  logic               rd_q;
  logic               done_q;
  logic               rx_q;
  logic [FRAME_W-1:0] sr;
  logic [LEN_W-1:0]   bit_cnt;
  logic [LEN_W-1:0]   len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      tail_q  <= 1'b0;
      sck_q   <= 1'b0;
      rd_q    <= 1'b0;
      done_q  <= 1'b0;
      rx_q    <= 1'b0;
      sr      <= '0;
      bit_cnt <= '0;
      len_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!run_q) begin
        if (start) begin
          run_q   <= 1'b1;
          tail_q  <= 1'b0;
          sck_q   <= 1'b0;
          sr      <= tx_word;
          bit_cnt <= '0;
          len_q   <= tx_len;
          rd_q    <= rd_en;
        end
      end else if (tick) begin
        if (tail_q) begin
          run_q  <= 1'b0;
          tail_q <= 1'b0;
          done_q <= 1'b1;
        end else if (!sck_q) begin
          sck_q <= 1'b1;
          if (rd_q && bit_cnt >= LEN_CMD) rx_q <= miso;
        end else begin
          sck_q <= 1'b0;
          sr    <= {sr[FRAME_W-2:0], 1'b0};
          if (bit_cnt == len_q - 1'b1) tail_q <= 1'b1;
          else bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  assign active = run_q;
  assign cs_n   = !run_q;
  assign sck    = sck_q;
  assign mosi   = run_q & sr[FRAME_W-1];
  assign done   = done_q;
  assign rx_bit = rx_q;
endmodule

// File: rtl/spi_erase_fsm.sv
module spi_erase_fsm
  import spi_erase_pkg::*;
#(
  parameter int CS_GAP    = 4,
  parameter int MAX_POLLS = 1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [23:0]        req_addr,
  input  logic               req_block,
  input  logic               eng_done,
  input  logic               busy_bit,
  output logic               req_ready,
  output logic               busy,
  output logic               done,
  output logic               timeout_err,
  output logic               start,
  output logic [FRAME_W-1:0] tx_word,
  output logic [LEN_W-1:0]   tx_len,
  output logic               rd_en
);
  localparam int GW = $clog2(CS_GAP + 1);
  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam logic [GW-1:0] GAP_LAST  = GW'(CS_GAP - 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(MAX_POLLS - 1);

  seq_state_t    state;
  logic [23:0]   addr_q;
  logic          blk_q;
  logic [GW-1:0] gap_cnt;
  logic [PW-1:0] poll_cnt;
  logic          done_q;
  logic          err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      addr_q   <= '0;
      blk_q    <= 1'b0;
      gap_cnt  <= '0;
      poll_cnt <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      start    <= 1'b0;
      tx_word  <= '0;
      tx_len   <= '0;
      rd_en    <= 1'b0;
    end else begin
      start  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            addr_q  <= req_addr;
            blk_q   <= req_block;
            start   <= 1'b1;
            tx_word <= {OP_WR_EN, 24'h0};
            tx_len  <= LEN_CMD;
            rd_en   <= 1'b0;
            state   <= ST_WREN;
          end
        end
        ST_WREN: begin
          if (eng_done) begin
            gap_cnt <= '0;
            state   <= ST_GAP_E;
          end
        end
        ST_GAP_E: begin
          if (gap_cnt == GAP_LAST) begin
            start   <= 1'b1;
            tx_word <= {(blk_q ? OP_ER_64K : OP_ER_4K), addr_q};
            tx_len  <= LEN_ERA;
            rd_en   <= 1'b0;
            state   <= ST_ERASE;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        ST_ERASE: begin
          if (eng_done) begin
            gap_cnt  <= '0;
            poll_cnt <= '0;
            state    <= ST_GAP_P;
          end
        end
        ST_GAP_P: begin
          if (gap_cnt == GAP_LAST) begin
            start   <= 1'b1;
            tx_word <= {OP_STATUS, 24'h0};
            tx_len  <= LEN_POLL;
            rd_en   <= 1'b1;
            state   <= ST_POLL;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        ST_POLL: begin
          if (eng_done) begin
            poll_cnt <= poll_cnt + 1'b1;
            gap_cnt  <= '0;
            if (!busy_bit) begin
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end else if (poll_cnt == POLL_LAST) begin
              err_q <= 1'b1;
              state <= ST_IDLE;
            end else begin
              state <= ST_GAP_P;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready   = (state == ST_IDLE);
  assign busy        = (state != ST_IDLE);
  assign done        = done_q;
  assign timeout_err = err_q;
endmodule

// File: rtl/spi_erase_seq.sv
module spi_erase_seq
  import spi_erase_pkg::*;
#(
  parameter int CLK_DIV   = 2,
  parameter int CS_GAP    = 4,
  parameter int MAX_POLLS = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [23:0] req_addr,
  input  logic        req_block,
  output logic        busy,
  output logic        done,
  output logic        timeout_err,
  output logic        spi_cs_n,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  logic               eng_start;
  logic [FRAME_W-1:0] eng_word;
  logic [LEN_W-1:0]   eng_len;
  logic               eng_rd;
  logic               eng_active;
  logic               eng_tick;
  logic               eng_done;
  logic               eng_rx;

  spi_tick_gen #(.HALF(CLK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (eng_active),
    .tick  (eng_tick)
  );

  spi_bit_engine u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (eng_start),
    .tx_word (eng_word),
    .tx_len  (eng_len),
    .rd_en   (eng_rd),
    .tick    (eng_tick),
    .miso    (spi_miso),
    .active  (eng_active),
    .cs_n    (spi_cs_n),
    .sck     (spi_sck),
    .mosi    (spi_mosi),
    .done    (eng_done),
    .rx_bit  (eng_rx)
  );

  spi_erase_fsm #(.CS_GAP(CS_GAP), .MAX_POLLS(MAX_POLLS)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_block   (req_block),
    .eng_done    (eng_done),
    .busy_bit    (eng_rx),
    .req_ready   (req_ready),
    .busy        (busy),
    .done        (done),
    .timeout_err (timeout_err),
    .start       (eng_start),
    .tx_word     (eng_word),
    .tx_len      (eng_len),
    .rd_en       (eng_rd)
  );
endmodule

// File: rtl/spi_erase_seq_chk.sv
module spi_erase_seq_chk #(
  parameter int CS_GAP = 4
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic busy,
  input logic done,
  input logic timeout_err,
  input logic spi_cs_n,
  input logic spi_sck,
  input logic spi_mosi
);
  logic [15:0] hi_cnt;
  logic        seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      seen   <= 1'b0;
    end else begin
      if (!spi_cs_n) hi_cnt <= '0;
      else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
      if (req_ready) seen <= 1'b0;
      else if (!spi_cs_n) seen <= 1'b1;
    end
  end

  // R5
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(spi_cs_n) && seen) |-> (hi_cnt >= 16'(CS_GAP)));

  // R8
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  // R8
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sck) |-> $stable(spi_mosi));

  // R7
  frame_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> (!req_ready && busy));

  // R7
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R6
  excl_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout_err));

  // R4
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout_err) |-> (req_ready && spi_cs_n));
endmodule

bind spi_erase_seq spi_erase_seq_chk #(.CS_GAP(CS_GAP)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .busy        (busy),
  .done        (done),
  .timeout_err (timeout_err),
  .spi_cs_n    (spi_cs_n),
  .spi_sck     (spi_sck),
  .spi_mosi    (spi_mosi)
);

// File: tb/test_spi_erase_seq.sv
module test_spi_erase_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 2;
  localparam int GAP  = 4;
  localparam int MAXP = 5;
  localparam int NVEC = 6;
  // {addr[24], block, busy polls[8]}
  localparam logic [32:0] VECS [0:NVEC-1] = '{
    {24'h123456, 1'b1, 8'd0},
    {24'hABCDEF, 1'b0, 8'd2},
    {24'hFFFFFF, 1'b1, 8'd4},
    {24'h000000, 1'b0, 8'd5},
    {24'h5A5A5A, 1'b1, 8'd9},
    {24'h00F001, 1'b0, 8'd1}
  };

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_block = 0;
  logic [23:0] req_addr = '0;
  logic req_ready, busy, done, timeout_err;
  logic spi_cs_n, spi_sck, spi_mosi;
  logic spi_miso = 0;

  int checks = 0, errors = 0, cyc = 0;
  int bitcnt = 0, nframes = 0, polls_seen = 0, busy_polls = 0;
  int t_rise = 0, min_gap = 100000;
  bit sck_bad = 0;
  logic [63:0] shreg = '0;
  logic [31:0] f_data [0:31];
  int f_len [0:31];

  spi_erase_seq #(.CLK_DIV(DIV), .CS_GAP(GAP), .MAX_POLLS(MAXP)) i_spi_erase_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_block(req_block), .busy(busy), .done(done),
    .timeout_err(timeout_err), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural flash
  always @(posedge spi_sck) if (!spi_cs_n) begin
    shreg = {shreg[62:0], spi_mosi};
    bitcnt = bitcnt + 1;
  end
  always @(negedge spi_sck) if (!spi_cs_n) begin
    if (bitcnt >= 8 && bitcnt < 16)
      spi_miso = (bitcnt == 15) ? (polls_seen < busy_polls) : 1'b0;
    else spi_miso = 1'b0;
  end
  always @(negedge spi_cs_n) begin
    if (spi_sck) sck_bad = 1;
    if (nframes > 0 && (cyc - t_rise) < min_gap) min_gap = cyc - t_rise;
    bitcnt = 0;
  end
  always @(posedge spi_cs_n) if (rst_n) begin
    t_rise = cyc;
    spi_miso = 1'b0;
    if (nframes < 32) begin
      f_data[nframes] = shreg[31:0];
      f_len[nframes]  = bitcnt;
    end
    if (bitcnt == 16 && shreg[15:8] == 8'h05) polls_seen = polls_seen + 1;
    nframes = nframes + 1;
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog act=%0d exp=<150000 cycles", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    nframes = 0; polls_seen = 0; min_gap = 100000; sck_bad = 0;
  endtask

  task automatic run_op(input logic [23:0] a, input logic b, input int bp,
                        input bit poke, output bit got_done, output bit got_err);
    clear_log();
    busy_polls = bp;
    got_done = 0; got_err = 0;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_block = b;
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < 8000 && !got_done && !got_err; i++) begin
      @(negedge clk);
      if (poke && i == 200) begin
        chk("R7 ready low mid-op", {63'd0, req_ready}, 64'd0);
        chk("R7 busy high mid-op", {63'd0, busy}, 64'd1);
        req_valid = 1; req_addr = 24'h777777; req_block = ~b;
        @(negedge clk);
        req_valid = 0;
      end
      if (done) got_done = 1;
      if (timeout_err) got_err = 1;
    end
    repeat (300) @(negedge clk);
  endtask

  task automatic check_op(input string nm, input logic [23:0] a, input logic b, input int bp,
                          input bit gd, input bit ge);
    int ep;
    bit eto;
    eto = (bp >= MAXP);
    ep = eto ? MAXP : bp + 1;
    chk({nm, " R2 wren len"}, 64'(f_len[0]), 64'd8);
    chk({nm, " R2 wren code"}, {56'd0, f_data[0][7:0]}, 64'h06);
    chk({nm, " R3 erase len"}, 64'(f_len[1]), 64'd32);
    chk({nm, " R3 erase word"}, {32'd0, f_data[1]}, {32'd0, (b ? 8'hD8 : 8'h20), a});
    chk({nm, " R4 frame count"}, 64'(nframes), 64'(2 + ep));
    chk({nm, " R4 polls"}, 64'(polls_seen), 64'(ep));
    chk({nm, " R4 done"}, {63'd0, gd}, {63'd0, !eto});
    chk({nm, " R6 timeout"}, {63'd0, ge}, {63'd0, eto});
    chk({nm, " R5 min gap ok"}, {63'd0, (min_gap >= GAP)}, 64'd1);
    chk({nm, " R8 sck low at cs fall"}, {63'd0, sck_bad}, 64'd0);
    chk({nm, " R7 ready after"}, {62'd0, req_ready, busy}, 64'b10);
  endtask

  initial begin
    bit gd, ge;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cs_n", {63'd0, spi_cs_n}, 64'd1);
    chk("R1 sck", {63'd0, spi_sck}, 64'd0);
    chk("R1 ready/busy", {62'd0, req_ready, busy}, 64'b10);
    chk("R1 done/err", {62'd0, done, timeout_err}, 64'b00);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1 idle after release", {62'd0, spi_cs_n, req_ready}, 64'b11);

    for (int v = 0; v < NVEC; v++) begin
      run_op(VECS[v][32:9], VECS[v][8], int'(VECS[v][7:0]), 0, gd, ge);
      check_op($sformatf("vec%0d", v), VECS[v][32:9], VECS[v][8], int'(VECS[v][7:0]), gd, ge);
    end

    // R7: request during polling is dropped
    run_op(24'h0C0FFE, 1'b1, 3, 1, gd, ge);
    check_op("R7 poke", 24'h0C0FFE, 1'b1, 3, gd, ge);
    clear_log();
    repeat (200) @(negedge clk);
    chk("R7 no frames after drop", 64'(nframes), 64'd0);

    // R1 reset in the middle of an erase
    clear_log();
    busy_polls = 20;
    @(negedge clk); req_valid = 1; req_addr = 24'h111111; req_block = 1;
    @(negedge clk); req_valid = 0;
    repeat (150) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk("R1 mid-op reset cs/sck", {62'd0, spi_cs_n, spi_sck}, 64'b10);
    chk("R1 mid-op reset ready", {62'd0, req_ready, busy}, 64'b10);
    rst_n = 1;
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule